// File: doc/BRIEF.md
# Accumulator Read Saturation Limiter

This block holds a small bank of wide accumulators and produces the 16-bit word that a word-sized move takes from one of them. Each accumulator is 36 bits: a 4-bit extension on top, then an upper 16-bit word, then a lower 16-bit word. On a read request the selected accumulator is examined. If its value fits in a 16-bit signed word, the upper word goes out unchanged. If it does not fit, a clipped constant with the largest magnitude and the correct sign is sent instead.

Every clip sets a sticky limit flag. The flag stays set until reset or an explicit clear. The accumulator itself is never changed by a read. A saturation-enable input can switch the limiter off, so the raw upper word always passes. The write port loads a full 36-bit value into either accumulator.

Top module: `sat_acc_limiter`

## Requirements
- R1: After synchronous reset, rd_data is 0x0000, rd_valid is 0 and lim_flag is 0.
- R2: With sat_en high, when bits [35:31] of the selected accumulator are all equal, rd_data is bits [31:16] unmodified and no clip is recorded.
- R3: With sat_en high, when bits [35:31] are not all equal and bit 35 is 0, rd_data is 0x7FFF.
- R4: With sat_en high, when bits [35:31] are not all equal and bit 35 is 1, rd_data is 0x8000.
- R5: A clip sets lim_flag. The flag then stays set through later reads that do not clip.
- R6: A flag_clr pulse clears lim_flag on the next edge. When flag_clr coincides with a clipping read, the flag is set.
- R7: With sat_en low, rd_data is always bits [31:16] and lim_flag is not set by that read.
- R8: rd_data, rd_valid and lim_flag change on the first clock edge after rd_req is sampled. rd_valid is high for exactly one cycle per request. rd_data holds its value while no read occurs.
- R9: A write and a read of the same accumulator in one cycle return the value held before the write. The written value appears on the next read.
- R10: A clipping read leaves the accumulator contents unchanged.
- R11: rd_sel (0 or 1) picks the accumulator that is read, and wr_sel picks the one that is written. A write to one accumulator does not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the accumulator bank |
| wr_sel | input | 1 | Accumulator index to write |
| wr_data | input | 36 | Full accumulator value to write |
| rd_req | input | 1 | Word-move read request |
| rd_sel | input | 1 | Accumulator index to read |
| sat_en | input | 1 | 1 enables limiting, 0 passes the raw upper word |
| flag_clr | input | 1 | Clears the sticky limit flag |
| rd_data | output | 16 | Registered read word |
| rd_valid | output | 1 | One-cycle strobe marking a new rd_data |
| lim_flag | output | 1 | Sticky limit flag |

## Verification
The hardest case to create from the ports is a flag clear that arrives in the same cycle as a clipping read. The stimulus first sets the flag, then asserts flag_clr and rd_req together on an accumulator loaded with an out-of-range value. A second hard case is proving the accumulator survives a clip, because only 16 bits are visible at the ports. To show this, the bench re-reads the same accumulator with sat_en low and expects the original upper word, then reads it again with sat_en high and expects the same clip. The write/read collision is forced by driving wr_en and rd_req on the same index in a single cycle.

// File: rtl/sat_lim_pkg.sv
package sat_lim_pkg;
  parameter int unsigned EXT_W   = 4;
  parameter int unsigned WORD_W  = 16;
  parameter int unsigned NUM_ACC = 2;

  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_POS  = 2'd1,
    CLIP_NEG  = 2'd2
  } clip_kind_t;
endpackage

// File: rtl/sat_acc_bank.sv
module sat_acc_bank #(
  parameter int unsigned ACC_W   = 36,
  parameter int unsigned NUM_ACC = 2,
  parameter int unsigned SEL_W   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [ACC_W-1:0] rd_word
);
  logic [ACC_W-1:0] mem [NUM_ACC];

  // Plain write port with no reset so the array maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_sel] <= wr_data;
  end

  // The read returns the stored value, which is the value before a write in the same cycle.
  assign rd_word = mem[rd_sel];
endmodule

// File: rtl/sat_ovf_detect.sv
module sat_ovf_detect
  import sat_lim_pkg::*;
#(
  parameter int unsigned EXT_W  = 4,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned GRD_W = EXT_W + 1
) (
  input  logic [GRD_W-1:0] guard_bits,
  output clip_kind_t       kind
);
  logic in_use;

  // The extension is unused when it only repeats the sign bit of the upper word.
  assign in_use = !((&guard_bits) || !(|guard_bits));

  always_comb begin
    if (!in_use)                kind = CLIP_NONE;
    else if (guard_bits[GRD_W-1]) kind = CLIP_NEG;
    else                        kind = CLIP_POS;
  end
endmodule

// File: rtl/sat_word_limiter.sv
module sat_word_limiter
  import sat_lim_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] upper_word,
  input  clip_kind_t        kind,
  input  logic              sat_en,
  output logic [WORD_W-1:0] out_word,
  output logic              clipped
);
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  always_comb begin
    out_word = upper_word;
    clipped  = 1'b0;
    if (sat_en) begin
      unique case (kind)
        CLIP_POS: begin out_word = MAX_POS; clipped = 1'b1; end
        CLIP_NEG: begin out_word = MAX_NEG; clipped = 1'b1; end
        default:  begin out_word = upper_word; clipped = 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sat_acc_limiter.sv
module sat_acc_limiter
  import sat_lim_pkg::*;
#(
  parameter int unsigned EXT_W   = sat_lim_pkg::EXT_W,
  parameter int unsigned WORD_W  = sat_lim_pkg::WORD_W,
  parameter int unsigned NUM_ACC = sat_lim_pkg::NUM_ACC,
  localparam int unsigned ACC_W  = EXT_W + 2 * WORD_W,
  localparam int unsigned SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              rd_req,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              sat_en,
  input  logic              flag_clr,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              lim_flag
);
  logic [ACC_W-1:0]  acc_word;
  logic [WORD_W-1:0] upper_word;
  logic [EXT_W:0]    guard_bits;
  clip_kind_t        kind;
  logic [WORD_W-1:0] lim_word;
  logic              clipped;
  logic              unused_low;

  sat_acc_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_word (acc_word)
  );

  assign upper_word = acc_word[ACC_W-EXT_W-1 -: WORD_W];
  assign guard_bits = acc_word[ACC_W-1 -: EXT_W+1];
  assign unused_low = ^acc_word[WORD_W-1:0];

  sat_ovf_detect #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_detect (
    .guard_bits (guard_bits),
    .kind       (kind)
  );

  sat_word_limiter #(.WORD_W(WORD_W)) u_limit (
    .upper_word (upper_word),
    .kind       (kind),
    .sat_en     (sat_en),
    .out_word   (lim_word),
    .clipped    (clipped)
  );

  sat_sticky_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .set_i  (rd_req && clipped),
    .clr_i  (flag_clr),
    .flag_o (lim_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= lim_word;
    end
  end
endmodule

// File: rtl/sat_lim_checker.sv
module sat_lim_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              sat_en,
  input logic              flag_clr,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              lim_flag
);
  localparam logic [WORD_W-1:0] MAX_POS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MAX_NEG = {1'b1, {(WORD_W-1){1'b0}}};

  a_r8_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid);
  a_r8_data_holds: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (lim_flag && !flag_clr) |=> lim_flag);
  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !rd_req) |=> !lim_flag);
  a_r7_bypass_no_flag: assert property (@(posedge clk) disable iff (rst)
    (!sat_en && !lim_flag && rd_req) |=> !lim_flag);
  a_r5_rise_needs_read: assert property (@(posedge clk) disable iff (rst)
    $rose(lim_flag) |-> rd_valid && (rd_data == MAX_POS || rd_data == MAX_NEG));
endmodule

bind sat_acc_limiter sat_lim_checker #(.WORD_W(WORD_W)) u_sat_lim_checker (
  .clk      (clk),
  .rst      (rst),
  .rd_req   (rd_req),
  .sat_en   (sat_en),
  .flag_clr (flag_clr),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .lim_flag (lim_flag)
);

// File: tb/test_sat_acc_limiter.sv
module test_sat_acc_limiter;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_sel, rd_req, rd_sel, sat_en, flag_clr;
  logic [35:0] wr_data;
  logic [15:0] rd_data;
  logic        rd_valid, lim_flag;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sat_acc_limiter i_sat_acc_limiter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .sat_en(sat_en), .flag_clr(flag_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .lim_flag(lim_flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [35:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Read with one cycle of latency; results sampled on the following falling edge.
  task automatic rd(input logic sel, input logic sat, input logic clr);
    rd_req = 1'b1; rd_sel = sel; sat_en = sat; flag_clr = clr;
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0; flag_clr = 1'b0; sat_en = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 data", rd_data, 16'h0000);
    chk("R1 valid", {15'd0, rd_valid}, 16'd0);
    chk("R1 flag", {15'd0, lim_flag}, 16'd0);
  endtask

  task automatic t_pass;
    wr(1'b0, 36'h0_1234_5678);
    rd(1'b0, 1'b1, 1'b0);
    chk("R2 pass word", rd_data, 16'h1234);
    chk("R8 valid", {15'd0, rd_valid}, 16'd1);
    chk("R2 no flag", {15'd0, lim_flag}, 16'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 valid drops", {15'd0, rd_valid}, 16'd0);
    chk("R8 data holds", rd_data, 16'h1234);
    wr(1'b1, 36'hF_8000_0001);
    rd(1'b1, 1'b1, 1'b0);
    chk("R2 negative fits", rd_data, 16'h8000);
    chk("R2 negative no flag", {15'd0, lim_flag}, 16'd0);
  endtask

  task automatic t_pos_clip;
    wr(1'b0, 36'h0_8000_0000);
    rd(1'b0, 1'b1, 1'b0);
    chk("R3 clip pos", rd_data, 16'h7FFF);
    chk("R5 flag set", {15'd0, lim_flag}, 16'd1);
    rd(1'b1, 1'b1, 1'b0);
    chk("R5 flag sticky", {15'd0, lim_flag}, 16'd1);
    rd(1'b0, 1'b0, 1'b0);
    chk("R10 upper intact", rd_data, 16'h8000);
    rd(1'b0, 1'b1, 1'b0);
    chk("R10 clips again", rd_data, 16'h7FFF);
  endtask

  task automatic t_clear;
    flag_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    flag_clr = 1'b0;
    chk("R6 cleared", {15'd0, lim_flag}, 16'd0);
  endtask

  task automatic t_neg_clip;
    wr(1'b1, 36'hF_7FFF_0000);
    rd(1'b1, 1'b1, 1'b0);
    chk("R4 clip neg", rd_data, 16'h8000);
    chk("R4 flag", {15'd0, lim_flag}, 16'd1);
    wr(1'b1, 36'h8_0000_0000);
    rd(1'b1, 1'b1, 1'b0);
    chk("R4 clip neg ext only", rd_data, 16'h8000);
    wr(1'b0, 36'h7_FFFF_FFFF);
    rd(1'b0, 1'b1, 1'b0);
    chk("R3 clip pos full", rd_data, 16'h7FFF);
  endtask

  task automatic t_clr_collide;
    rd(1'b0, 1'b1, 1'b1);
    chk("R6 set beats clear", {15'd0, lim_flag}, 16'd1);
  endtask

  task automatic t_bypass;
    t_clear();
    rd(1'b0, 1'b0, 1'b0);
    chk("R7 raw word", rd_data, 16'hFFFF);
    chk("R7 no flag", {15'd0, lim_flag}, 16'd0);
  endtask

  task automatic t_rw_collide;
    wr(1'b0, 36'h0_1111_0000);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 36'h0_2222_0000;
    rd(1'b0, 1'b1, 1'b0);
    wr_en = 1'b0;
    chk("R9 old value", rd_data, 16'h1111);
    rd(1'b0, 1'b1, 1'b0);
    chk("R9 new value", rd_data, 16'h2222);
  endtask

  task automatic t_select;
    wr(1'b1, 36'h0_3333_0000);
    rd(1'b0, 1'b1, 1'b0);
    chk("R11 acc0 untouched", rd_data, 16'h2222);
    rd(1'b1, 1'b1, 1'b0);
    chk("R11 acc1", rd_data, 16'h3333);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_req = 1'b0; rd_sel = 1'b0; sat_en = 1'b1; flag_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pass();
    t_pos_clip();
    t_clear();
    t_neg_clip();
    t_clr_collide();
    t_bypass();
    t_rw_collide();
    t_select();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule